// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic stage of a small microcontroller core. Each accepted operation takes an opcode, two operands (a register value and either a second register value or an immediate) and the core's current status flags. It returns a result byte, a new six-bit flag word and a write strobe for the destination. Every operation touches only its own subset of the flags. Flags it does not own are copied from the flag input.

Byte operations complete one cycle after they are accepted. The two word operations, add and subtract of an immediate on a 16-bit register pair, run the low byte and then the high byte through the same adder over two cycles. They report busy in between. Subtract-with-carry and compare-with-carry only ever clear the zero flag. When the flag output is fed back into the flag input from byte to byte, a multi-byte subtract or compare therefore ends with a zero flag that reflects the whole multi-byte value. The register file, the instruction decoder and the multiplier live elsewhere.

Top module: `alu8_core`

## Requirements
- R1: After reset, busy, done, wr_lo and wr_hi are 0, and res_lo, res_hi and flags_out are 0.
- R2: When op_valid is 1 and busy is 0, the operation is accepted. The opcode values are: ADD=0, ADC=1, SUB=2, SBC=3, CP=4, CPC=5, AND=6, OR=7, XOR=8, COM=9, NEG=10, INC=11, DEC=12, SER=13, WADD=14, WSUB=15. For opcodes 0 to 13, done is 1 for exactly the next cycle. In that cycle res_lo holds the result, res_hi is 0 and wr_hi is 0. In flags_out, bit 0 is C, bit 1 is Z, bit 2 is N, bit 3 is V, bit 4 is S and bit 5 is H. Every flag bit that an operation does not update equals the corresponding bit of flags_in.
- R3: ADD computes opa+opb and ADC computes opa+opb+C. SUB computes opa-opb and SBC computes opa-opb-C. All four write the result (wr_lo=1) and update all six flags. C is the carry out of bit 7 for addition and the borrow out of bit 7 for subtraction. H is the carry out of bit 3 for addition and the borrow into bit 4 for subtraction. V is two's-complement overflow. N is result bit 7. Z is 1 when the result is zero.
- R4: For SBC and CPC, Z is 1 only when the result is zero and flags_in Z is 1. Otherwise Z is 0.
- R5: CP and CPC produce the same res_lo and flags as SUB and SBC, but with wr_lo=0.
- R6: AND, OR and XOR write the bitwise result. They set V to 0, update Z, N and S, and keep C and H from flags_in.
- R7: COM writes 0xFF minus opa. It sets C to 1 and V to 0, updates Z, N and S, and keeps H.
- R8: NEG writes 0x00 minus opa and updates all six flags. C is 1 when opa is nonzero, V is 1 when opa is 0x80, and H is 1 when the low nibble of opa is nonzero.
- R9: INC writes opa+1 and DEC writes opa-1, both modulo 256. They update Z, N, V and S and keep C and H. V is 1 for INC of 0x7F and for DEC of 0x80.
- R10: SER writes 0xFF with wr_lo=1 and sets flags_out equal to flags_in.
- R11: WADD and WSUB compute {opa_hi,opa} plus or minus the zero-extended opb as a 16-bit value. busy is 1 for the cycle after acceptance. In the cycle after that, done, wr_lo and wr_hi are all 1 and {res_hi,res_lo} holds the 16-bit result. C, Z, N, V and S describe the 16-bit operation. H, and the flags_in value sampled at acceptance, carry through unchanged.
- R12: op_valid is ignored while busy is 1. An operation presented in that cycle never produces a done.
- R13: In every operation that updates flags, S equals N XOR V.
- R14: In a cycle with no completing operation, done, wr_lo and wr_hi are 0, and res_lo, res_hi and flags_out keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 4 | Operation select |
| opa | input | 8 | Destination operand; low byte for word operations |
| opa_hi | input | 8 | High byte of the register pair for word operations |
| opb | input | 8 | Second operand or immediate |
| flags_in | input | 6 | Current status flags |
| busy | output | 1 | Word operation in its second cycle |
| done | output | 1 | Result and flags valid this cycle |
| wr_lo | output | 1 | Write strobe for res_lo |
| wr_hi | output | 1 | Write strobe for res_hi |
| res_lo | output | 8 | Result byte, or low byte of a word result |
| res_hi | output | 8 | High byte of a word result |
| flags_out | output | 6 | Updated status flags |

## Verification
The bench builds the block with its default 8-bit width and behavioural adder.

At that width it is practical to run every value of opa against sixteen chosen values of opb through every byte opcode. The flag input varies alongside, so each carry-in and zero-in combination occurs. Those opb values include 0x00, 0x01, 0x0F, 0x10, 0x7F, 0x80 and 0xFF, which puts the half-carry, overflow and borrow corners within reach.

Word operations sweep every high byte against edge low bytes and immediates. This covers carry and borrow across the byte boundary and a zero result over all 16 bits. Dedicated sequences cover a two-byte zero-flag chain, a request made while busy, and idle cycles.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   localparam int FLAG_W = 6;
   localparam int FC = 0;
   localparam int FZ = 1;
   localparam int FN = 2;
   localparam int FV = 3;
   localparam int FS = 4;
   localparam int FH = 5;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADC  = 4'd1,
      OP_SUB  = 4'd2,
      OP_SBC  = 4'd3,
      OP_CP   = 4'd4,
      OP_CPC  = 4'd5,
      OP_AND  = 4'd6,
      OP_OR   = 4'd7,
      OP_XOR  = 4'd8,
      OP_COM  = 4'd9,
      OP_NEG  = 4'd10,
      OP_INC  = 4'd11,
      OP_DEC  = 4'd12,
      OP_SER  = 4'd13,
      OP_WADD = 4'd14,
      OP_WSUB = 4'd15
   } op_e;

   typedef enum logic {AS_OPA, AS_ZERO} asel_e;
   typedef enum logic [1:0] {BS_OPB, BS_OPA, BS_ONE, BS_ZERO} bsel_e;

   // Flag-update masks, bit order H S V N Z C
   localparam logic [FLAG_W-1:0] M_NONE   = 6'b000000;
   localparam logic [FLAG_W-1:0] M_ARITH  = 6'b111111;
   localparam logic [FLAG_W-1:0] M_LOGIC  = 6'b011110;
   localparam logic [FLAG_W-1:0] M_COM    = 6'b011111;
   localparam logic [FLAG_W-1:0] M_INCDEC = 6'b011110;
   localparam logic [FLAG_W-1:0] M_WORD   = 6'b011111;

   typedef struct packed {
      asel_e             a_sel;
      bsel_e             b_sel;
      logic              sub;
      logic              use_cin;
      logic              is_logic;
      logic              wb;
      logic              zchain;
      logic              word;
      logic [FLAG_W-1:0] mask;
   } ctl_t;

   function automatic ctl_t decode(op_e op);
      ctl_t c;
      c = '0;
      c.a_sel = AS_OPA;
      c.b_sel = BS_OPB;
      c.wb    = 1'b1;
      case (op)
         OP_ADD:  c.mask = M_ARITH;
         OP_ADC:  begin c.use_cin = 1'b1; c.mask = M_ARITH; end
         OP_SUB:  begin c.sub = 1'b1; c.mask = M_ARITH; end
         OP_SBC:  begin c.sub = 1'b1; c.use_cin = 1'b1; c.zchain = 1'b1; c.mask = M_ARITH; end
         OP_CP:   begin c.sub = 1'b1; c.wb = 1'b0; c.mask = M_ARITH; end
         OP_CPC:  begin
            c.sub = 1'b1; c.use_cin = 1'b1; c.zchain = 1'b1; c.wb = 1'b0; c.mask = M_ARITH;
         end
         OP_AND, OP_OR, OP_XOR: begin c.is_logic = 1'b1; c.mask = M_LOGIC; end
         OP_COM:  begin c.is_logic = 1'b1; c.mask = M_COM; end
         OP_NEG:  begin
            c.a_sel = AS_ZERO; c.b_sel = BS_OPA; c.sub = 1'b1; c.mask = M_ARITH;
         end
         OP_INC:  begin c.b_sel = BS_ONE; c.mask = M_INCDEC; end
         OP_DEC:  begin c.b_sel = BS_ONE; c.sub = 1'b1; c.mask = M_INCDEC; end
         OP_SER:  begin c.is_logic = 1'b1; c.mask = M_NONE; end
         OP_WADD: begin c.word = 1'b1; c.mask = M_WORD; end
         OP_WSUB: begin c.word = 1'b1; c.sub = 1'b1; c.mask = M_WORD; end
         default: c.mask = M_NONE;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int W        = 8,
   parameter int HB       = 4,
   parameter bit RIPPLE   = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         hout,
   output logic         vout
);

   logic [W-1:0] bx;
   logic         ci;
   logic         c_top;
   logic         c_half;

   // Subtraction is a + ~b + ~borrow; carries are inverted back to borrows
   assign bx = sub ? ~b : b;
   assign ci = sub ? ~cin : cin;

   if (RIPPLE) begin : g_ripple
      logic [W:0] carry;
      assign carry[0] = ci;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sum[i]     = a[i] ^ bx[i] ^ carry[i];
         assign carry[i+1] = (a[i] & bx[i]) | (carry[i] & (a[i] ^ bx[i]));
      end
      assign c_top  = carry[W];
      assign c_half = carry[HB];
   end else begin : g_behav
      logic [W:0] full;
      assign full   = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, ci};
      assign sum    = full[W-1:0];
      assign c_top  = full[W];
      assign c_half = ({1'b0, a[HB-1:0]} + {1'b0, bx[HB-1:0]} + {{HB{1'b0}}, ci})
                      > {1'b0, {HB{1'b1}}};
   end

   assign cout = sub ? ~c_top  : c_top;
   assign hout = sub ? ~c_half : c_half;
   assign vout = (a[W-1] == bx[W-1]) & (sum[W-1] ^ a[W-1]);

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  op_e          op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] res
);

   always_comb begin
      case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_COM:  res = ~a;
         OP_SER:  res = '1;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/alu8_flagmerge.sv
module alu8_flagmerge
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [FLAG_W-1:0] fl_base,
   input  logic [FLAG_W-1:0] mask,
   input  logic [W-1:0]      res,
   input  logic              zchain,
   input  logic              z_prev,
   input  logic              raw_c,
   input  logic              raw_v,
   input  logic              raw_h,
   output logic [FLAG_W-1:0] fl_out
);

   logic              z_new;
   logic              n_new;
   logic [FLAG_W-1:0] fl_new;

   assign z_new = ~|res & (~zchain | z_prev);
   assign n_new = res[W-1];

   always_comb begin
      fl_new     = '0;
      fl_new[FC] = raw_c;
      fl_new[FZ] = z_new;
      fl_new[FN] = n_new;
      fl_new[FV] = raw_v;
      fl_new[FS] = n_new ^ raw_v;
      fl_new[FH] = raw_h;
   end

   assign fl_out = (mask & fl_new) | (~mask & fl_base);

endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int HALF_POS     = DATA_W / 2,
   parameter bit RIPPLE_CARRY = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  op_valid,
   input  logic [3:0]            op_code,
   input  logic [DATA_W-1:0]     opa,
   input  logic [DATA_W-1:0]     opa_hi,
   input  logic [DATA_W-1:0]     opb,
   input  logic [FLAG_W-1:0]     flags_in,
   output logic                  busy,
   output logic                  done,
   output logic                  wr_lo,
   output logic                  wr_hi,
   output logic [DATA_W-1:0]     res_lo,
   output logic [DATA_W-1:0]     res_hi,
   output logic [FLAG_W-1:0]     flags_out
);

   localparam logic [DATA_W-1:0] ONE_W = DATA_W'(1);

   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("alu8_core: DATA_W must be even and at least 4");
   end
   if (HALF_POS < 1 || HALF_POS >= DATA_W) begin : g_bad_half
      $error("alu8_core: HALF_POS must lie inside the data word");
   end

   // Second-cycle state of a word operation
   logic                busy_q;
   op_e                 op_q;
   logic [DATA_W-1:0]   hi_q;
   logic [DATA_W-1:0]   lo_q;
   logic                cy_q;
   logic                zlo_q;
   logic [FLAG_W-1:0]   fbase_q;

   // Output registers
   logic                done_q;
   logic                wr_lo_q;
   logic                wr_hi_q;
   logic [DATA_W-1:0]   res_lo_q;
   logic [DATA_W-1:0]   res_hi_q;
   logic [FLAG_W-1:0]   flags_q;

   op_e                 op_cur;
   ctl_t                ctl;
   logic [DATA_W-1:0]   add_a;
   logic [DATA_W-1:0]   add_b;
   logic                add_cin;
   logic [DATA_W-1:0]   add_sum;
   logic                add_c;
   logic                add_h;
   logic                add_v;
   logic [DATA_W-1:0]   lg_res;
   logic [DATA_W-1:0]   res_mux;
   logic [FLAG_W-1:0]   fl_base;
   logic                z_prev;
   logic                zchain_eff;
   logic                raw_c;
   logic                raw_v;
   logic [FLAG_W-1:0]   fl_new;

   assign op_cur = busy_q ? op_q : op_e'(op_code);
   assign ctl    = decode(op_cur);

   always_comb begin
      if (busy_q) begin
         add_a   = hi_q;
         add_b   = '0;
         add_cin = cy_q;
      end else begin
         add_a   = (ctl.a_sel == AS_ZERO) ? '0 : opa;
         case (ctl.b_sel)
            BS_OPB:  add_b = opb;
            BS_OPA:  add_b = opa;
            BS_ONE:  add_b = ONE_W;
            default: add_b = '0;
         endcase
         add_cin = ctl.use_cin & flags_in[FC];
      end
   end

   alu8_addsub #(
      .W      (DATA_W),
      .HB     (HALF_POS),
      .RIPPLE (RIPPLE_CARRY)
   ) u_addsub (
      .a    (add_a),
      .b    (add_b),
      .sub  (ctl.sub),
      .cin  (add_cin),
      .sum  (add_sum),
      .cout (add_c),
      .hout (add_h),
      .vout (add_v)
   );

   alu8_logic #(
      .W (DATA_W)
   ) u_logic (
      .op  (op_cur),
      .a   (opa),
      .b   (opb),
      .res (lg_res)
   );

   assign res_mux    = ctl.is_logic ? lg_res : add_sum;
   assign raw_c      = ctl.is_logic | add_c;
   assign raw_v      = ~ctl.is_logic & add_v;
   assign fl_base    = busy_q ? fbase_q : flags_in;
   assign z_prev     = busy_q ? zlo_q : flags_in[FZ];
   assign zchain_eff = busy_q | ctl.zchain;

   alu8_flagmerge #(
      .W (DATA_W)
   ) u_flags (
      .fl_base (fl_base),
      .mask    (ctl.mask),
      .res     (res_mux),
      .zchain  (zchain_eff),
      .z_prev  (z_prev),
      .raw_c   (raw_c),
      .raw_v   (raw_v),
      .raw_h   (add_h),
      .fl_out  (fl_new)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         op_q     <= OP_ADD;
         hi_q     <= '0;
         lo_q     <= '0;
         cy_q     <= 1'b0;
         zlo_q    <= 1'b0;
         fbase_q  <= '0;
         done_q   <= 1'b0;
         wr_lo_q  <= 1'b0;
         wr_hi_q  <= 1'b0;
         res_lo_q <= '0;
         res_hi_q <= '0;
         flags_q  <= '0;
      end else begin
         done_q  <= 1'b0;
         wr_lo_q <= 1'b0;
         wr_hi_q <= 1'b0;
         if (busy_q) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b1;
            wr_lo_q  <= 1'b1;
            wr_hi_q  <= 1'b1;
            res_lo_q <= lo_q;
            res_hi_q <= add_sum;
            flags_q  <= fl_new;
         end else if (op_valid) begin
            if (ctl.word) begin
               busy_q  <= 1'b1;
               op_q    <= op_cur;
               hi_q    <= opa_hi;
               lo_q    <= add_sum;
               cy_q    <= add_c;
               zlo_q   <= ~|add_sum;
               fbase_q <= flags_in;
            end else begin
               done_q   <= 1'b1;
               wr_lo_q  <= ctl.wb;
               res_lo_q <= res_mux;
               res_hi_q <= '0;
               flags_q  <= fl_new;
            end
         end
      end
   end

   assign busy      = busy_q;
   assign done      = done_q;
   assign wr_lo     = wr_lo_q;
   assign wr_hi     = wr_hi_q;
   assign res_lo    = res_lo_q;
   assign res_hi    = res_hi_q;
   assign flags_out = flags_q;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [3:0]        op_code,
   input logic [FLAG_W-1:0] flags_in,
   input logic              busy,
   input logic              done,
   input logic              wr_lo,
   input logic              wr_hi,
   input logic [DATA_W-1:0] res_lo,
   input logic [DATA_W-1:0] res_hi,
   input logic [FLAG_W-1:0] flags_out
);

   logic take_byte;
   assign take_byte = op_valid && !busy && (op_code < OP_WADD);

   // R11
   word_second_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy && done && wr_lo && wr_hi));

   // R2
   byte_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_byte |=> (done && !wr_hi && res_hi == '0 && !busy));

   // R5
   cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !busy && (op_code == OP_CP || op_code == OP_CPC)) |=> (done && !wr_lo));

   // R9
   incdec_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !busy && (op_code == OP_INC || op_code == OP_DEC))
      |=> (flags_out[FC] == $past(flags_in[FC]) && flags_out[FH] == $past(flags_in[FH])));

   // R10
   ser_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !busy && op_code == OP_SER)
      |=> (res_lo == '1 && wr_lo && flags_out == $past(flags_in)));

   // R13
   sign_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_byte && op_code != OP_SER) |=> (flags_out[FS] == (flags_out[FN] ^ flags_out[FV])));

   // R13
   sign_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (flags_out[FS] == (flags_out[FN] ^ flags_out[FV])));

   // R14
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && !busy)
      |=> (!done && !wr_lo && !wr_hi && $stable(res_lo) && $stable(res_hi) && $stable(flags_out)));

   // R2
   wr_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo || wr_hi) |-> done);

endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_code   (op_code),
   .flags_in  (flags_in),
   .busy      (busy),
   .done      (done),
   .wr_lo     (wr_lo),
   .wr_hi     (wr_hi),
   .res_lo    (res_lo),
   .res_hi    (res_hi),
   .flags_out (flags_out)
);

// File: tb/alu8_core_bench.sv
module alu8_core_bench;

   logic       clk;
   logic       rst_n;
   logic       op_valid;
   logic [3:0] op_code;
   logic [7:0] opa;
   logic [7:0] opa_hi;
   logic [7:0] opb;
   logic [5:0] flags_in;
   logic       busy;
   logic       done;
   logic       wr_lo;
   logic       wr_hi;
   logic [7:0] res_lo;
   logic [7:0] res_hi;
   logic [5:0] flags_out;

   int n_chk;
   int n_err;

   alu8_core u_alu8_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_code   (op_code),
      .opa       (opa),
      .opa_hi    (opa_hi),
      .opb       (opb),
      .flags_in  (flags_in),
      .busy      (busy),
      .done      (done),
      .wr_lo     (wr_lo),
      .wr_hi     (wr_hi),
      .res_lo    (res_lo),
      .res_hi    (res_hi),
      .flags_out (flags_out)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int sx(input int x);
      return (x > 127) ? x - 256 : x;
   endfunction

   function automatic string tag_of(input int op);
      case (op)
         0, 1, 2: return "R2 R3 R13";
         3:       return "R2 R3 R4 R13";
         4:       return "R2 R5 R13";
         5:       return "R2 R4 R5 R13";
         6, 7, 8: return "R2 R6 R13";
         9:       return "R2 R7 R13";
         10:      return "R2 R8 R13";
         11, 12:  return "R2 R9 R13";
         default: return "R2 R10";
      endcase
   endfunction

   // {wr, result, flags}
   function automatic logic [14:0] model_byte(input int op, input int a, input int b,
                                              input logic [5:0] f);
      int s, r, ci, sv;
      logic wr;
      logic [5:0] o;
      o = f; wr = 1'b1; r = 0; ci = 0;
      case (op)
         0, 1: begin
            ci = (op == 1) ? int'(f[0]) : 0;
            s = a + b + ci; r = s & 255;
            o[0] = (s > 255);
            o[5] = ((a & 15) + (b & 15) + ci) > 15;
            sv = sx(a) + sx(b) + ci;
            o[3] = (sv > 127) || (sv < -128);
         end
         2, 3, 4, 5: begin
            ci = (op == 3 || op == 5) ? int'(f[0]) : 0;
            s = a - b - ci; r = s & 255;
            o[0] = (s < 0);
            o[5] = ((a & 15) - (b & 15) - ci) < 0;
            sv = sx(a) - sx(b) - ci;
            o[3] = (sv > 127) || (sv < -128);
            wr = !(op == 4 || op == 5);
         end
         6:  begin r = a & b; o[3] = 1'b0; end
         7:  begin r = a | b; o[3] = 1'b0; end
         8:  begin r = a ^ b; o[3] = 1'b0; end
         9:  begin r = 255 - a; o[0] = 1'b1; o[3] = 1'b0; end
         10: begin
            r = (256 - a) & 255;
            o[0] = (a != 0);
            o[5] = ((a & 15) != 0);
            o[3] = (a == 128);
         end
         11: begin r = (a + 1) & 255; o[3] = (a == 127); end
         12: begin r = (a + 255) & 255; o[3] = (a == 128); end
         default: r = 255;
      endcase
      if (op != 13) begin
         o[1] = (r == 0);
         if (op == 3 || op == 5) o[1] = (r == 0) && f[1];
         o[2] = ((r & 128) != 0);
         o[4] = o[2] ^ o[3];
      end
      return {wr, 8'(r), o};
   endfunction

   // {result16, flags}
   function automatic logic [21:0] model_word(input bit add, input int hi, input int lo,
                                              input int k, input logic [5:0] f);
      int x, s, r;
      logic n;
      logic [5:0] o;
      o = f;
      x = hi * 256 + lo;
      s = add ? x + k : x - k;
      r = s & 65535;
      n = ((r & 32768) != 0);
      o[0] = add ? (s > 65535) : (s < 0);
      o[1] = (r == 0);
      o[2] = n;
      o[3] = add ? (hi < 128 && n) : (hi >= 128 && !n);
      o[4] = o[2] ^ o[3];
      return {16'(r), o};
   endfunction

   function automatic logic [7:0] bpick(input int j);
      case (j)
         0: return 8'h00;  1: return 8'h01;  2: return 8'h0F;  3: return 8'h10;
         4: return 8'h7F;  5: return 8'h80;  6: return 8'hFF;  7: return 8'h08;
         8: return 8'h37;  9: return 8'hC9; 10: return 8'h55; 11: return 8'hAA;
        12: return 8'hF0; 13: return 8'h81; 14: return 8'h7E; default: return 8'hFE;
      endcase
   endfunction

   function automatic logic [24:0] outs();
      return {done, wr_hi, wr_lo, res_hi, res_lo, flags_out};
   endfunction

   // Inputs driven at a falling edge; result sampled at the next falling edge
   task automatic run_byte(input int op, input int a, input int b, input logic [5:0] f);
      logic [14:0] e;
      op_valid = 1'b1; op_code = 4'(op); opa = 8'(a); opb = 8'(b);
      opa_hi = 8'(a) ^ 8'h5A; flags_in = f;
      e = model_byte(op, a, b, f);
      @(negedge clk);
      chk(tag_of(op), {7'd0, outs()}, {7'd0, 1'b1, 1'b0, e[14], 8'h00, e[13:6], e[5:0]});
   endtask

   task automatic run_word(input bit add, input int hi, input int lo, input int k,
                           input logic [5:0] f);
      logic [21:0] e;
      op_valid = 1'b1; op_code = add ? 4'd14 : 4'd15;
      opa = 8'(lo); opa_hi = 8'(hi); opb = 8'(k); flags_in = f;
      e = model_word(add, hi, lo, k, f);
      @(negedge clk);
      chk("R11 busy", {30'd0, busy, done}, {30'd0, 1'b1, 1'b0});
      op_valid = 1'b0; flags_in = ~f;
      @(negedge clk);
      chk("R11 R13 word", {7'd0, outs()}, {7'd0, 3'b111, e});
      chk("R11 idle", {31'd0, busy}, 32'd0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL R2 watchdog expired actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [5:0] fcap;
      logic [24:0] hold;
      n_chk = 0; n_err = 0;
      rst_n = 1'b0; op_valid = 1'b0; op_code = '0;
      opa = '0; opa_hi = '0; opb = '0; flags_in = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 reset", {6'd0, busy, outs()}, 32'd0);

      // Byte sweep: every opa, sixteen opb values, all byte opcodes
      for (int a = 0; a < 256; a++) begin
         for (int j = 0; j < 16; j++) begin
            for (int op = 0; op < 14; op++) begin
               run_byte(op, a, int'(bpick(j)), 6'((a ^ (j * 5) ^ (op * 7)) & 63));
            end
         end
      end
      op_valid = 1'b0;
      @(negedge clk);

      // Word sweep
      for (int hi = 0; hi < 256; hi++) begin
         for (int li = 0; li < 4; li++) begin
            for (int ki = 0; ki < 4; ki++) begin
               int lo, k;
               lo = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 128 : 255;
               k  = (ki == 0) ? 0 : (ki == 1) ? 1 : (ki == 2) ? 63 : 255;
               run_word(1'b1, hi, lo, k, 6'((hi + li * 9 + ki) & 63));
               run_word(1'b0, hi, lo, k, 6'((hi ^ (li * 13) ^ ki) & 63));
            end
         end
      end

      // R4 chain: 0x0100 - 0x0100 ends with Z=1
      run_byte(2, 8'h00, 8'h00, 6'h00);
      fcap = flags_out;
      run_byte(3, 8'h01, 8'h01, fcap);
      chk("R4 chain zero", {31'd0, flags_out[1]}, 32'd1);
      // R4 chain: 0x0101 - 0x0100 ends with Z=0
      run_byte(2, 8'h01, 8'h00, 6'h00);
      fcap = flags_out;
      run_byte(5, 8'h01, 8'h01, fcap);
      chk("R4 chain nonzero", {31'd0, flags_out[1]}, 32'd0);

      // R12: request while busy is ignored
      op_valid = 1'b1; op_code = 4'd14; opa = 8'h34; opa_hi = 8'h12; opb = 8'h01; flags_in = 6'h20;
      @(negedge clk);
      chk("R12 busy", {31'd0, busy}, 32'd1);
      op_code = 4'd13; opa = 8'h00; flags_in = 6'h0F;
      @(negedge clk);
      chk("R12 word result", {7'd0, outs()}, {7'd0, 3'b111, 16'h1235, 6'h20});
      op_valid = 1'b0;
      @(negedge clk);
      chk("R12 no late done", {7'd0, outs()}, {7'd0, 3'b000, 16'h1235, 6'h20});

      // R14: idle cycles keep the outputs
      run_byte(10, 8'h80, 8'h00, 6'h00);
      op_valid = 1'b0;
      hold = outs();
      @(negedge clk);
      chk("R14 hold 1", {7'd0, outs()}, {7'd0, 3'b000, hold[21:0]});
      opa = 8'hFF; opb = 8'h11; flags_in = 6'h3F; op_code = 4'd0;
      @(negedge clk);
      chk("R14 hold 2", {7'd0, outs()}, {7'd0, 3'b000, hold[21:0]});

      finish_run();
   end

endmodule